// File: doc/BRIEF.md
# Data-Selected Transfer Sequence Controller

This block serves one dedicated trigger source. A request that arrives with nothing suspended first reads a fixed word of the internal data memory. The low eight bits of that word select one of 256 entries in a start-pointer table. Each entry points to the first descriptor of a sequence in descriptor memory. The controller then runs descriptors at consecutive addresses through a small internal mover. Each descriptor copies words inside the data memory in one of three styles: normal, repeat or block.

Two flags in a descriptor decide what happens after it runs. An end flag finishes the whole sequence and raises a completion pulse. A divide flag parks the sequence, raises a separate pulse, and remembers where to continue. The next request then skips the index read and resumes at the following descriptor. Counters and addresses that a descriptor changes are written back to descriptor memory, so a later run continues from them.

Tables, descriptors and data words are loaded through one write port while the controller is idle. Every word the mover writes is also shown on a registered write-event output.

Top module: `seqx_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `split` and `wr_valid` are low, and the first request performs an index read.
- R2: A request with nothing suspended reads the data word at parameter `IDX_ADDR`. Bits [7:0] of that word index the 256-entry start-pointer table, and the sequence starts at the descriptor that entry names.
- R3: Descriptors run at consecutive addresses until one has the end flag set. Then `done` pulses for one cycle, and the next request performs a new index read. The end flag takes priority over the divide flag.
- R4: A descriptor with the divide flag set and the end flag clear stops the run. Then `split` pulses for one cycle, and the next request resumes at the next descriptor address with no index read.
- R5: Mode 0 (normal) moves one word per run. The source address and the destination address each advance by their 1-bit step. The count decrements, and all three are written back.
- R6: Mode 1 (repeat) moves one word per run. If the count was 1, the count reloads from the size field and both addresses reload from their base fields. Otherwise the count decrements.
- R7: Mode 2 (block) moves size-field words per run, with a size of 0 acting as 1. The addresses advance across the beats and are kept, and the count decrements once.
- R8: Each word moved reads the source address and writes the destination address of data memory. A later read sees the new value. `wr_valid` pulses with `wr_addr`/`wr_data` for each word.
- R9: A request that arrives while `busy` is high is ignored.
- R10: The pulse appears N edges after the edge that samples the request. N = 3 (fresh) or 1 (resumed), plus 3+2b for each descriptor run, where b is that descriptor's word count.
- R11: `busy` stays high from the sampling edge until the pulse. It falls in the cycle the pulse appears, and `done` and `split` are never high together.
- R12: `cfg_sel` codes are 0 = data word, 1 = descriptor, 2 = start pointer. A descriptor packs, from MSB to LSB: end flag, divide flag, mode[1:0], source step, destination step, size[7:0], count[7:0], destination base, source base, destination, source (8 bits each). A run performs exactly the words its configuration implies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request from the trigger source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 data, 1 descriptor, 2 start table |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 54 | Configuration data (descriptor-wide) |
| busy | output | 1 | Sequence run in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| split | output | 1 | One-cycle pulse: sequence divided |
| wr_valid | output | 1 | Mover wrote a word |
| wr_addr | output | 8 | Destination address of that word |
| wr_data | output | 32 | Data of that word |

## Verification
Each write event appears one cycle after the mover's read-to-write step of that word. The `done` or `split` pulse appears exactly N edges after the sampling edge, with N as given by the latency rule. The reference model computes N for every run together with the queue of expected writes. The bench counts edges from the request and samples at each falling edge. At every cycle it compares the write event against the head of the queue and checks `busy` for the run still in progress. The pulse kind and the latency are judged on the cycle the pulse appears, and one more idle cycle after it confirms that a poked request had no effect.

// File: rtl/seqx_pkg.sv
package seqx_pkg;
  localparam int DW = 32;  // data word width
  localparam int AW = 8;   // data memory address width
  localparam int PW = 6;   // descriptor pointer width
  localparam int CW = 8;   // count / size width
  localparam int IW = 8;   // sequence index width (256 sequences)

  typedef enum logic [1:0] {
    MD_NORM = 2'd0,
    MD_RPT  = 2'd1,
    MD_BLK  = 2'd2,
    MD_RSV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CS_DATA = 2'd0,
    CS_DESC = 2'd1,
    CS_TBL  = 2'd2,
    CS_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic          eos;
    logic          div;
    mode_e         mode;
    logic          sinc;
    logic          dinc;
    logic [CW-1:0] rsz;
    logic [CW-1:0] cnt;
    logic [AW-1:0] dbase;
    logic [AW-1:0] sbase;
    logic [AW-1:0] dst;
    logic [AW-1:0] src;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/seqx_ram.sv
module seqx_ram #(
  parameter int W = 8,
  parameter int A = 8
) (
  input  logic         clk,
  input  logic         we,
  input  logic [A-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [A-1:0] raddr,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << A;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seqx_step.sv
module seqx_step
  import seqx_pkg::*;
(
  input  desc_t cur,
  output desc_t wb
);
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = cur.cnt - CW'(1);

  always_comb begin
    wb = cur;
    case (cur.mode)
      MD_RPT: begin
        if (cur.cnt == CW'(1)) begin
          wb.cnt = cur.rsz;
          wb.src = cur.sbase;
          wb.dst = cur.dbase;
        end else begin
          wb.cnt = cnt_dec;
        end
      end
      default: wb.cnt = cnt_dec;
    endcase
  end
endmodule

// File: rtl/seqx_ctrl.sv
module seqx_ctrl
  import seqx_pkg::*;
#(
  parameter logic [AW-1:0] IDX_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IW-1:0]     cfg_addr,
  input  logic [DESC_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              done,
  output logic              split,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_IRD, S_TRD, S_DRD, S_DLD, S_XRD, S_XWR, S_WB
  } st_e;

  st_e           state;
  logic [PW-1:0] ptr, saved;
  logic          susp;
  desc_t         cur, wb, q_rdata;
  logic [CW-1:0] beats;
  logic          done_q, split_q, wr_valid_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;

  // data memory
  logic              d_we;
  logic [AW-1:0]     d_waddr, d_raddr;
  logic [DW-1:0]     d_wdata, d_rdata;
  // start table
  logic              t_we;
  logic [PW-1:0]     t_rdata;
  // descriptor memory
  logic              q_we;
  logic [PW-1:0]     q_waddr;
  logic [DESC_W-1:0] q_wdata, q_rdata_v;

  assign d_we    = (state == S_XWR) || (cfg_we && cfg_sel == CS_DATA);
  assign d_waddr = (state == S_XWR) ? cur.dst : cfg_addr[AW-1:0];
  assign d_wdata = (state == S_XWR) ? d_rdata : cfg_wdata[DW-1:0];
  assign d_raddr = (state == S_IDLE) ? IDX_ADDR : cur.src;

  assign t_we    = cfg_we && cfg_sel == CS_TBL;

  assign q_we    = (state == S_WB) || (cfg_we && cfg_sel == CS_DESC);
  assign q_waddr = (state == S_WB) ? ptr : cfg_addr[PW-1:0];
  assign q_wdata = (state == S_WB) ? DESC_W'(wb) : cfg_wdata;
  assign q_rdata = desc_t'(q_rdata_v);

  seqx_ram #(.W(DW), .A(AW)) u_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  seqx_ram #(.W(PW), .A(IW)) u_tbl (
    .clk(clk), .we(t_we), .waddr(cfg_addr), .wdata(cfg_wdata[PW-1:0]),
    .raddr(d_rdata[IW-1:0]), .rdata(t_rdata)
  );

  seqx_ram #(.W(DESC_W), .A(PW)) u_desc (
    .clk(clk), .we(q_we), .waddr(q_waddr), .wdata(q_wdata),
    .raddr(ptr), .rdata(q_rdata_v)
  );

  seqx_step u_step (.cur(cur), .wb(wb));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ptr        <= '0;
      saved      <= '0;
      susp       <= 1'b0;
      cur        <= '0;
      beats      <= '0;
      done_q     <= 1'b0;
      split_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      split_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            if (susp) begin
              ptr   <= saved;
              state <= S_DRD;
            end else begin
              state <= S_IRD;
            end
          end
        end
        S_IRD: state <= S_TRD;
        S_TRD: begin
          ptr   <= t_rdata;
          state <= S_DRD;
        end
        S_DRD: state <= S_DLD;
        S_DLD: begin
          cur   <= q_rdata;
          beats <= (q_rdata.mode == MD_BLK && q_rdata.rsz != '0) ? q_rdata.rsz : CW'(1);
          state <= S_XRD;
        end
        S_XRD: state <= S_XWR;
        S_XWR: begin
          wr_valid_q <= 1'b1;
          wr_addr_q  <= cur.dst;
          wr_data_q  <= d_rdata;
          cur.src    <= cur.src + AW'(cur.sinc);
          cur.dst    <= cur.dst + AW'(cur.dinc);
          beats      <= beats - CW'(1);
          state      <= (beats == CW'(1)) ? S_WB : S_XRD;
        end
        S_WB: begin
          if (wb.eos) begin
            done_q <= 1'b1;
            susp   <= 1'b0;
            state  <= S_IDLE;
          end else if (wb.div) begin
            split_q <= 1'b1;
            susp    <= 1'b1;
            saved   <= ptr + PW'(1);
            state   <= S_IDLE;
          end else begin
            ptr   <= ptr + PW'(1);
            state <= S_DRD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign split    = split_q;
  assign wr_valid = wr_valid_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && split));

  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || split));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  split_resume_chk: assert property (@(posedge clk) disable iff (rst)
    split |-> (susp && !busy));

  // R8
  wr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy);

  // R9
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req && state != S_WB) |=> busy);
endmodule

// File: tb/seqx_ctrl_test.sv
module seqx_ctrl_test;
  import seqx_pkg::*;

  localparam logic [AW-1:0] IDX = 8'hF0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [IW-1:0]     cfg_addr = '0;
  logic [DESC_W-1:0] cfg_wdata = '0;
  logic              busy, done, split, wr_valid;
  logic [AW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;

  seqx_ctrl #(.IDX_ADDR(IDX)) uut (
    .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy), .done(done),
    .split(split), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_data [256];
  bit            m_wr   [256];
  desc_t         m_desc [64];
  logic [PW-1:0] m_tbl  [256];
  bit            m_susp = 1'b0;
  logic [PW-1:0] m_saved = '0;
  exp_t          q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic desc_t mkd(input logic [7:0] s, input logic [7:0] d, input logic [7:0] c,
                                input logic [7:0] r, input mode_e md, input bit si, input bit di,
                                input bit e, input bit v);
    desc_t x;
    x.eos = e; x.div = v; x.mode = md; x.sinc = si; x.dinc = di;
    x.rsz = r; x.cnt = c; x.dbase = d; x.sbase = s; x.dst = d; x.src = s;
    return x;
  endfunction

  function automatic string tagof(input mode_e md);
    if (md == MD_RPT) return "R6";
    if (md == MD_BLK) return "R7";
    return "R5";
  endfunction

  task automatic cfg(input logic [1:0] sel, input int addr, input logic [DESC_W-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = IW'(addr); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) begin m_data[addr] = val[DW-1:0]; m_wr[addr] = 1'b0; end
    if (sel == 2'd1) m_desc[addr] = desc_t'(val);
    if (sel == 2'd2) m_tbl[addr] = val[PW-1:0];
  endtask

  task automatic model(output int kind, output int ncyc);
    logic [PW-1:0] p;
    desc_t d;
    int b;
    bit first;
    exp_t e;
    first = !m_susp;
    p = m_susp ? m_saved : m_tbl[m_data[IDX][7:0]];
    ncyc = m_susp ? 1 : 3;
    kind = 0;
    for (int g = 0; g < 64; g++) begin
      d = m_desc[p];
      b = (d.mode == MD_BLK && d.rsz != 0) ? int'(d.rsz) : 1;
      for (int k = 0; k < b; k++) begin
        e.a = d.dst;
        e.d = m_data[d.src];
        e.tag = first ? "R2" : (m_wr[d.src] ? "R8" : tagof(d.mode));
        first = 1'b0;
        q.push_back(e);
        m_data[d.dst] = m_data[d.src];
        m_wr[d.dst] = 1'b1;
        d.src = d.src + 8'(d.sinc);
        d.dst = d.dst + 8'(d.dinc);
      end
      ncyc += 3 + 2 * b;
      if (d.mode == MD_RPT && d.cnt == 8'd1) begin
        d.cnt = d.rsz; d.src = d.sbase; d.dst = d.dbase;
      end else begin
        d.cnt = d.cnt - 8'd1;
      end
      m_desc[p] = d;
      if (d.eos) begin kind = 0; m_susp = 1'b0; break; end
      if (d.div) begin kind = 1; m_susp = 1'b1; m_saved = p + PW'(1); break; end
      p = p + PW'(1);
    end
  endtask

  task automatic run_req(input int poke);
    int kind, nexp, n;
    exp_t e;
    model(kind, nexp);
    req = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req = (poke > 0 && n == poke);
      check(!(done && split), "R11 both pulses", {done, split}, 0);
      if (!(done || split)) check(busy == 1'b1, "R11 busy during run", busy, 1);
      if (wr_valid) begin
        if (q.size() == 0) check(1'b0, "R12 extra write", wr_addr, 0);
        else begin
          e = q.pop_front();
          check({wr_addr, wr_data} == {e.a, e.d}, e.tag, {wr_addr, wr_data}, {e.a, e.d});
        end
      end
      if (done || split) begin
        check(split == kind[0], kind ? "R4 pulse kind" : "R3 pulse kind", split, kind);
        check(n == nexp, "R10 latency", n, nexp);
        check(busy == 1'b0, "R11 idle at pulse", busy, 0);
        check(q.size() == 0, "R12 missing writes", q.size(), 0);
        break;
      end
      if (n > 4000) begin
        check(1'b0, "R10 no pulse", n, nexp);
        break;
      end
    end
    req = 1'b0;
    q.delete();
    @(negedge clk);
    check(!busy && !done && !split && !wr_valid,
          poke > 0 ? "R9 poke ignored" : "R3 quiet after pulse",
          {busy, done, split, wr_valid}, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check(!busy && !done && !split && !wr_valid, "R1 reset state",
          {busy, done, split, wr_valid}, 0);

    for (int i = 0; i < 256; i++) cfg(2'd0, i, DESC_W'(32'hA500_0000 + i * 3));
    for (int i = 0; i < 256; i++) cfg(2'd2, i, DESC_W'(63));
    for (int i = 0; i < 64; i++) cfg(2'd1, i, mkd(8'h08, 8'hC0, 8'd4, 8'd1, MD_NORM, 1, 1, 1, 0));
    cfg(2'd2, 7,   DESC_W'(0));
    cfg(2'd2, 0,   DESC_W'(10));
    cfg(2'd2, 255, DESC_W'(20));
    cfg(2'd2, 3,   DESC_W'(30));
    cfg(2'd1, 0,  mkd(8'h10, 8'h40, 8'd5, 8'd1, MD_NORM, 1, 1, 0, 1));
    cfg(2'd1, 1,  mkd(8'h20, 8'h50, 8'd2, 8'd3, MD_BLK,  1, 1, 0, 0));
    cfg(2'd1, 2,  mkd(8'h40, 8'h60, 8'd5, 8'd1, MD_NORM, 1, 1, 1, 0));
    cfg(2'd1, 10, mkd(8'h05, 8'hB0, 8'd9, 8'd1, MD_NORM, 1, 1, 0, 0));
    cfg(2'd1, 11, mkd(8'h30, 8'h70, 8'd2, 8'd2, MD_RPT,  1, 1, 1, 0));
    cfg(2'd1, 20, mkd(8'h00, 8'h90, 8'd3, 8'd4, MD_BLK,  1, 0, 1, 1));
    cfg(2'd1, 30, mkd(8'h18, 8'hA0, 8'd3, 8'd1, MD_NORM, 1, 1, 0, 1));
    cfg(2'd1, 31, mkd(8'h1C, 8'hA8, 8'd3, 8'd1, MD_NORM, 0, 1, 0, 1));
    cfg(2'd1, 32, mkd(8'h1E, 8'hAC, 8'd3, 8'd1, MD_NORM, 1, 0, 1, 0));

    // R2 R4: index 7, split after first descriptor, then resume (R8 via 0x40)
    cfg(2'd0, IDX, DESC_W'(32'h1234_5607));
    run_req(0);
    run_req(0);
    // R6: repeat reload across three runs, index 0 boundary
    cfg(2'd0, IDX, DESC_W'(32'h0000_0100));
    run_req(0);
    run_req(0);
    run_req(0);
    // R7: block with fixed destination, both flags set (end wins), index 255
    cfg(2'd0, IDX, DESC_W'(32'hFFFF_FFFF));
    run_req(0);
    run_req(0);
    // R4 R5: two divisions then completion
    cfg(2'd0, IDX, DESC_W'(32'h0000_0003));
    run_req(0);
    run_req(0);
    run_req(0);
    // R9: poke during run, then index 7 again with updated counts
    cfg(2'd0, IDX, DESC_W'(32'h0000_0007));
    run_req(2);
    run_req(5);
    // default entry
    cfg(2'd0, IDX, DESC_W'(32'h0000_0064));
    run_req(0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule